// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that a compiler hoisted above earlier stores. When such a load issues, its destination register, its byte address and its access width go into one table slot. The load's own memory access happens elsewhere; this block only tracks it. Each store presents its byte range to the table, and every tracked load whose bytes overlap the store is dropped. At the load's original program position, a check names the destination register and asks whether a live entry still exists. An entry that is present means the early load is still valid. An entry that is missing means the speculation failed and recovery code must run.

The insert, store and check ports each carry a one-cycle valid strobe and never apply back-pressure. The block accepts every strobe in the cycle it is presented, so it has no ready signals. The check port answers exactly one cycle after its strobe with a done pulse and a hit flag. Lookups for checks and for re-inserts match on the register number. Invalidation matches on address-range overlap.

Top module: `spec_ld_table`

## Requirements
- R1: After reset, every slot is empty, and a check for any register returns `chk_done`=1 with `chk_hit`=0.
- R2: The result of a check appears on `chk_done`/`chk_hit` in the cycle after `chk_valid`. `chk_done` is 1 only in that cycle.
- R3: After an insert, a check on the same register returns hit=1, and a check on a register that was never inserted returns hit=0.
- R4: A store whose byte range overlaps a live entry's range invalidates that entry. Every overlapping entry is invalidated in the same cycle.
- R5: Ranges are half-open, [addr, addr+bytes), and computed without address wrap. A store that only touches the bytes next to an entry's range leaves the entry live.
- R6: The 2-bit size code c means 2^c bytes: 0=1, 1=2, 2=4, 3=8. Overlap is judged with that width for both the entry and the store.
- R7: An insert for a register that already has a live entry overwrites that entry's address and size in place. Afterwards only the new range is snooped.
- R8: An insert that matches no live register goes to the lowest-numbered empty slot. When every slot is live, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one only on such replacements.
- R9: When a store and an insert occur in the same cycle, the store's invalidation applies first. The new entry survives even if its range overlaps the store.
- R10: A check reports the table contents as they were before any store or insert in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert strobe for an early load |
| ins_reg | input | REG_W | Destination register of the load |
| ins_addr | input | ADDR_W | Load byte address |
| ins_size | input | 2 | Size code of the load (2^code bytes) |
| st_valid | input | 1 | Store snoop strobe |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Check strobe |
| chk_reg | input | REG_W | Register to look up |
| chk_done | output | 1 | Check answer valid, one cycle after the strobe |
| chk_hit | output | 1 | 1: entry present (speculation held); 0: absent |

## Verification
The bench uses the default build of 8 slots, 7-bit register numbers and 32-bit addresses. With 8 slots, filling the table and forcing two successive round-robin replacements takes only a handful of inserts. A slot freed by a store then shows that empty slots take priority over the pointer. The 32-bit address width lets an 8-byte entry sit at the very top of the address space, which exercises the carry in the end-of-range sum. Adjacent and one-byte-overlapping stores at each size code probe the half-open boundary.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
  typedef logic [1:0] size_code_t;

  // width in bytes of a size code: 2^code
  function automatic logic [3:0] code_bytes(size_code_t c);
    return 4'd1 << c;
  endfunction
endpackage

// File: rtl/spec_ld_slot_cmp.sv
module spec_ld_slot_cmp
  import spec_ld_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              slot_live,
  input  logic [REG_W-1:0]  slot_reg,
  input  logic [ADDR_W-1:0] slot_addr,
  input  size_code_t        slot_size,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic [ADDR_W-1:0] st_addr,
  input  size_code_t        st_size,
  output logic              ins_same_reg,
  output logic              chk_same_reg,
  output logic              st_overlap
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] s_lo, s_hi, w_lo, w_hi;

  always_comb begin
    s_lo = {1'b0, slot_addr};
    s_hi = s_lo + EW'(code_bytes(slot_size));
    w_lo = {1'b0, st_addr};
    w_hi = w_lo + EW'(code_bytes(st_size));
    ins_same_reg = slot_live && (slot_reg == ins_reg);
    chk_same_reg = slot_live && (slot_reg == chk_reg);
    st_overlap   = slot_live && (w_lo < s_hi) && (s_lo < w_hi);
  end
endmodule

// File: rtl/spec_ld_victim.sv
module spec_ld_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] reg_match,
  output logic [IDX_W-1:0]   slot,
  output logic               evicting
);
  logic [IDX_W-1:0] rr_ptr;

  always_comb begin
    slot     = rr_ptr;
    evicting = 1'b0;
    if (|reg_match) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (reg_match[i]) slot = IDX_W'(i);
    end else if (!(&live)) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!live[i]) slot = IDX_W'(i);
    end else begin
      evicting = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_ptr <= '0;
    else if (ins_valid && evicting)
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
  end

  // R8: pointer moves exactly on a full-table replacement
  assert_rr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && evicting && rr_ptr != IDX_W'(ENTRIES - 1)) |=> rr_ptr == $past(rr_ptr) + 1'b1);
  assert_rr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && evicting) |=> $stable(rr_ptr));
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
  import spec_ld_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_done,
  output logic              chk_hit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [REG_W-1:0]   reg_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  size_code_t         size_q [ENTRIES];

  logic [ENTRIES-1:0] ins_same, chk_same, st_hit, kill, live, ins_match;
  logic [IDX_W-1:0]   wr_slot;
  logic               evicting;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    spec_ld_slot_cmp #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_cmp (
      .slot_live    (valid_q[g]),
      .slot_reg     (reg_q[g]),
      .slot_addr    (addr_q[g]),
      .slot_size    (size_q[g]),
      .ins_reg      (ins_reg),
      .chk_reg      (chk_reg),
      .st_addr      (st_addr),
      .st_size      (st_size),
      .ins_same_reg (ins_same[g]),
      .chk_same_reg (chk_same[g]),
      .st_overlap   (st_hit[g])
    );
  end

  // store acts before the insert of the same cycle
  assign kill      = st_valid ? st_hit : '0;
  assign live      = valid_q & ~kill;
  assign ins_match = ins_same & live;

  spec_ld_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .live      (live),
    .reg_match (ins_match),
    .slot      (wr_slot),
    .evicting  (evicting)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= live;
      if (ins_valid) valid_q[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      reg_q[wr_slot]  <= ins_reg;
      addr_q[wr_slot] <= ins_addr;
      size_q[wr_slot] <= ins_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      chk_hit  <= 1'b0;
    end else begin
      chk_done <= chk_valid;
      chk_hit  <= chk_valid && (|chk_same);
    end
  end

  // R7: one live slot per register at most
  assert_one_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_same));
  // R2: answer exactly one cycle after the strobe
  assert_answer_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);
  assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done && !chk_hit);
  // R3: written slot is live next cycle
  assert_insert_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> valid_q[$past(wr_slot)]);
  // R4/R9: overlapped slots drop unless refilled by the same-cycle insert
  assert_store_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ins_valid) |=> (valid_q & $past(st_hit)) == '0);
endmodule

// File: tb/spec_ld_table_bench.sv
module spec_ld_table_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, st_valid = 0, chk_valid = 0;
  logic [6:0]  ins_reg = '0, chk_reg = '0;
  logic [31:0] ins_addr = '0, st_addr = '0;
  logic [1:0]  ins_size = '0, st_size = '0;
  logic chk_done, chk_hit;
  logic got_done, got_hit;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  spec_ld_table u_spec_ld_table (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr), .ins_size(ins_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .chk_done(chk_done), .chk_hit(chk_hit));

  // called at a negedge; drives one cycle, returns at next negedge
  task automatic step(input logic iv, input logic [6:0] ir, input logic [31:0] ia, input logic [1:0] is,
                      input logic sv, input logic [31:0] sa, input logic [1:0] ss,
                      input logic cv, input logic [6:0] cr);
    ins_valid = iv; ins_reg = ir; ins_addr = ia; ins_size = is;
    st_valid = sv; st_addr = sa; st_size = ss;
    chk_valid = cv; chk_reg = cr;
    @(negedge clk);
    got_done = chk_done; got_hit = chk_hit;
    ins_valid = 0; st_valid = 0; chk_valid = 0;
  endtask

  task automatic ins(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
    step(1, r, a, s, 0, 0, 0, 0, 0);
  endtask

  task automatic st(input logic [31:0] a, input logic [1:0] s);
    step(0, 0, 0, 0, 1, a, s, 0, 0);
  endtask

  task automatic expect_chk(input logic [6:0] r, input logic exp, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, r);
    n_run++;
    if (got_done !== 1'b1 || got_hit !== exp) begin
      n_fail++;
      $display("FAIL %s reg=%0d done=%b hit=%b expected done=1 hit=%b", req, r, got_done, got_hit, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();   // R1, R2
    do_reset();
    n_run++;
    if (chk_done !== 1'b0) begin
      n_fail++; $display("FAIL R2 idle done=%b expected 0", chk_done);
    end
    expect_chk(7'd5, 1'b0, "R1");
    @(negedge clk);
    n_run++;
    if (chk_done !== 1'b0) begin
      n_fail++; $display("FAIL R2 done held=%b expected 0", chk_done);
    end
  endtask

  task automatic t_basic();   // R3
    do_reset();
    ins(7'd10, 32'h100, 2'd2);
    expect_chk(7'd10, 1'b1, "R3");
    expect_chk(7'd11, 1'b0, "R3");
  endtask

  task automatic t_overlap(); // R4, R5, R6
    do_reset();
    ins(7'd1, 32'h200, 2'd3);        // [0x200,0x208)
    ins(7'd2, 32'h204, 2'd1);        // [0x204,0x206)
    ins(7'd3, 32'h300, 2'd0);        // [0x300,0x301)
    st(32'h208, 2'd3);               // adjacent above r1
    st(32'h1F8, 2'd3);               // adjacent below r1
    st(32'h301, 2'd0);               // adjacent to r3
    expect_chk(7'd1, 1'b1, "R5");
    expect_chk(7'd3, 1'b1, "R5");
    st(32'h205, 2'd0);               // hits r1 and r2
    expect_chk(7'd1, 1'b0, "R4");
    expect_chk(7'd2, 1'b0, "R4");
    expect_chk(7'd3, 1'b1, "R4");
    st(32'h2FE, 2'd1);               // [0x2FE,0x300) misses r3
    expect_chk(7'd3, 1'b1, "R6");
    st(32'h2FE, 2'd2);               // [0x2FE,0x302) hits r3
    expect_chk(7'd3, 1'b0, "R6");
    ins(7'd4, 32'hFFFF_FFF8, 2'd3);  // top of space
    st(32'hFFFF_FFF0, 2'd3);
    expect_chk(7'd4, 1'b1, "R5");
    st(32'hFFFF_FFFC, 2'd2);
    expect_chk(7'd4, 1'b0, "R6");
  endtask

  task automatic t_rewrite(); // R7
    do_reset();
    ins(7'd20, 32'h400, 2'd2);
    ins(7'd20, 32'h500, 2'd2);
    st(32'h400, 2'd2);
    expect_chk(7'd20, 1'b1, "R7");
    st(32'h502, 2'd0);
    expect_chk(7'd20, 1'b0, "R7");
  endtask

  task automatic t_replace(); // R8
    do_reset();
    for (int i = 0; i < 8; i++) ins(7'(i + 1), 32'h1000 + 32'(i * 16), 2'd2);
    ins(7'd9, 32'h2000, 2'd2);       // evicts slot 0 (reg 1)
    ins(7'd10, 32'h2010, 2'd2);      // evicts slot 1 (reg 2)
    expect_chk(7'd1, 1'b0, "R8");
    expect_chk(7'd2, 1'b0, "R8");
    expect_chk(7'd3, 1'b1, "R8");
    expect_chk(7'd9, 1'b1, "R8");
    st(32'h1040, 2'd0);              // frees slot 4 (reg 5)
    ins(7'd11, 32'h2020, 2'd2);      // fills slot 4, pointer stays
    expect_chk(7'd4, 1'b1, "R8");
    expect_chk(7'd11, 1'b1, "R8");
    ins(7'd12, 32'h2030, 2'd2);      // evicts slot 2 (reg 3)
    expect_chk(7'd3, 1'b0, "R8");
    expect_chk(7'd4, 1'b1, "R8");
  endtask

  task automatic t_same_cycle(); // R9, R10
    do_reset();
    ins(7'd30, 32'h600, 2'd3);
    step(1, 7'd31, 32'h600, 2'd2, 1, 32'h600, 2'd3, 0, 0);
    expect_chk(7'd30, 1'b0, "R9");
    expect_chk(7'd31, 1'b1, "R9");
    step(0, 0, 0, 0, 1, 32'h600, 2'd0, 1, 7'd31); // check sees pre-store
    n_run++;
    if (got_done !== 1'b1 || got_hit !== 1'b1) begin
      n_fail++; $display("FAIL R10 hit=%b expected 1", got_hit);
    end
    expect_chk(7'd31, 1'b0, "R10");
    step(1, 7'd32, 32'h700, 2'd0, 0, 0, 0, 1, 7'd32); // check before insert
    n_run++;
    if (got_hit !== 1'b0) begin
      n_fail++; $display("FAIL R10 hit=%b expected 0", got_hit);
    end
    expect_chk(7'd32, 1'b1, "R10");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_overlap();
    t_rewrite();
    t_replace();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule